// File: doc/BRIEF.md
# Indirect-Access DMA Channel Programming Front End

This block is the register front end of a multi-channel DMA engine. Software reaches it through two byte-wide I/O locations: a command port and a data port. A byte written to the command port names an operation and a target channel. The data-port accesses that follow move bytes into that channel's I/O-port, address, count or mode register, least significant byte first. An internal byte pointer steps through the bytes and stops at the register's width. Two "get" operations return the live address or the remaining count through data-port reads.

Each channel also holds a mask bit. A channel is active when it is unmasked and its mode enables transfers. On every transfer-done strobe for an active channel, the block steps the address by the unit size and decrements the remaining count. When the count runs out, the block flags terminal count and masks the channel itself.

Software programs a channel in this order: mask it, write the mode, load the address, load the count, then unmask it. The transfer engine reads the selected channel's address, port and mode through a registered lookup.

Top module: `dma_cmd_front`

## Requirements
- R1: After a synchronous reset, all channels are masked and their registers are zero. Every `tc_flag` bit is 0 and `bus_rdata` is 0. No command is in force, so data-port writes are ignored until a command byte arrives.
- R2: A write to offset 0x18 is a command byte. Bits 7:4 are the opcode and bits 3:0 are the channel. Data accesses use offset 0x1A, and writes to any other offset have no effect. Each command byte restarts the byte pointer at zero.
- R3: Opcode 0x2 takes 3 data bytes for the 24-bit address, low byte first. Opcode 0x3 returns the current address on successive data reads, low byte first. Each read byte appears on `bus_rdata` one cycle after the read.
- R4: Opcode 0x4 takes 2 data bytes for the 16-bit count, low byte first. The count holds the number of units minus one. Opcode 0x5 returns the remaining count on successive data reads, low byte first.
- R5: Opcode 0x0 takes 2 data bytes for the 16-bit I/O port number, low byte first.
- R6: Opcode 0x7 takes 1 data byte for the mode. In the mode byte, bit 2 enables transfers, bit 3 selects read (0 selects write), bit 0 selects an I/O-register target, and bit 6 selects 16-bit units (0 selects 8-bit).
- R7: The following have no effect:
  - data writes beyond the byte length of the current command;
  - data writes before any command;
  - unassigned opcodes (0x1, 0x6, 0x8, 0xB to 0xF);
  - commands that name a channel number of `NCH` or above.
- R8: Opcode 0x9 masks the named channel and opcode 0xA unmasks it. `ch_active[i]` is 1 exactly when channel i is unmasked and its mode bit 2 is set. A strobe to an inactive channel changes nothing.
- R9: A `xfer_done` strobe to an active channel adds 1 to its address in 8-bit mode, or 2 in 16-bit mode. The same strobe decrements its count.
- R10: A strobe to an active channel whose count is 0 does three things: it sets the count to 0xFFFF, sets `tc_flag` for that channel, and masks the channel in the same cycle. Unmasking the channel clears its `tc_flag`.
- R11: A data read returns 0 and leaves the pointer unchanged in either case: the current command is not a get command, or all of its bytes have already been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | BUS_AW | I/O offset of the access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |
| xfer_done | input | 1 | One transfer unit finished |
| xfer_ch | input | 4 | Channel of the finished unit |
| sel_ch | input | 4 | Channel looked up for the engine |
| sel_addr | output | ADDR_W | Address of `sel_ch`, registered |
| sel_iop | output | IOP_W | I/O port of `sel_ch`, registered |
| sel_mode | output | 8 | Mode of `sel_ch`, registered |
| ch_active | output | NCH | Per-channel unmasked-and-enabled |
| tc_flag | output | NCH | Per-channel terminal count reached |

## Verification
The timing of each result depends on where it comes from:
- Register writes, mask changes and strobes take effect at the clock edge that samples them. `ch_active` and `tc_flag` therefore change at that edge.
- The `sel_*` lookup adds one more register stage, so a write shows there two edges after it is sampled.
- A read byte is on `bus_rdata` after the edge that sampled the read.

The bench keeps a behavioural model that it updates on the same edges. It compares the model against the outputs at every falling edge. Directed checks wait exactly one idle cycle after a strobe, or two after a write, before sampling `sel_*`.

// File: rtl/dma_fe_pkg.sv
package dma_fe_pkg;
  localparam logic [3:0] OP_SET_IOP  = 4'h0;
  localparam logic [3:0] OP_SET_ADDR = 4'h2;
  localparam logic [3:0] OP_GET_ADDR = 4'h3;
  localparam logic [3:0] OP_SET_CNT  = 4'h4;
  localparam logic [3:0] OP_GET_CNT  = 4'h5;
  localparam logic [3:0] OP_SET_MODE = 4'h7;
  localparam logic [3:0] OP_MASK     = 4'h9;
  localparam logic [3:0] OP_UNMASK   = 4'hA;

  // mode byte bit positions
  localparam int MB_IO   = 0;
  localparam int MB_EN   = 2;
  localparam int MB_RD   = 3;
  localparam int MB_WIDE = 6;

  typedef struct packed {
    logic       iop;
    logic       addr;
    logic       cnt;
    logic       mode;
    logic [1:0] idx;
    logic [3:0] ch;
    logic [7:0] data;
  } fe_wr_t;

  typedef struct packed {
    logic       go;
    logic       sel_cnt;
    logic [1:0] idx;
    logic [3:0] ch;
  } fe_rd_t;
endpackage

// File: rtl/dma_fe_decode.sv
module dma_fe_decode import dma_fe_pkg::*; #(
  parameter int                BUS_AW     = 8,
  parameter logic [BUS_AW-1:0] CMD_OFS    = 8'h18,
  parameter logic [BUS_AW-1:0] DATA_OFS   = 8'h1A,
  parameter int                ADDR_BYTES = 3,
  parameter int                CNT_BYTES  = 2,
  parameter int                IOP_BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output fe_wr_t            wr_o,
  output fe_rd_t            rd_o,
  output logic              mask_o,
  output logic              unmask_o,
  output logic [3:0]        cmd_ch_o
);
  logic [3:0] op_q, ch_q;
  logic       vld_q;
  logic [1:0] ptr_q;
  logic [1:0] len;
  logic       cmd_hit, dat_wr, dat_rd, in_rng, advance;

  assign cmd_hit = bus_wr && (bus_addr == CMD_OFS);
  assign dat_wr  = bus_wr && (bus_addr == DATA_OFS);
  assign dat_rd  = bus_rd && (bus_addr == DATA_OFS);

  always_comb begin
    case (op_q)
      OP_SET_IOP:              len = 2'(IOP_BYTES);
      OP_SET_ADDR, OP_GET_ADDR: len = 2'(ADDR_BYTES);
      OP_SET_CNT, OP_GET_CNT:   len = 2'(CNT_BYTES);
      OP_SET_MODE:             len = 2'd1;
      default:                 len = 2'd0;
    endcase
  end

  assign in_rng = vld_q && (ptr_q < len);

  always_comb begin
    wr_o.iop   = dat_wr && in_rng && (op_q == OP_SET_IOP);
    wr_o.addr  = dat_wr && in_rng && (op_q == OP_SET_ADDR);
    wr_o.cnt   = dat_wr && in_rng && (op_q == OP_SET_CNT);
    wr_o.mode  = dat_wr && in_rng && (op_q == OP_SET_MODE);
    wr_o.idx   = ptr_q;
    wr_o.ch    = ch_q;
    wr_o.data  = bus_wdata;
    rd_o.go      = dat_rd && in_rng && ((op_q == OP_GET_ADDR) || (op_q == OP_GET_CNT));
    rd_o.sel_cnt = (op_q == OP_GET_CNT);
    rd_o.idx     = ptr_q;
    rd_o.ch      = ch_q;
  end

  assign advance  = wr_o.iop || wr_o.addr || wr_o.cnt || wr_o.mode || rd_o.go;
  assign mask_o   = cmd_hit && (bus_wdata[7:4] == OP_MASK);
  assign unmask_o = cmd_hit && (bus_wdata[7:4] == OP_UNMASK);
  assign cmd_ch_o = bus_wdata[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= '0;
      ch_q  <= '0;
      vld_q <= 1'b0;
      ptr_q <= '0;
    end else if (cmd_hit) begin
      op_q  <= bus_wdata[7:4];
      ch_q  <= bus_wdata[3:0];
      vld_q <= 1'b1;
      ptr_q <= '0;
    end else if (advance) begin
      ptr_q <= ptr_q + 2'd1;
    end
  end
endmodule

// File: rtl/dma_fe_chan.sv
module dma_fe_chan import dma_fe_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int IOP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_iop,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              wr_mode,
  input  logic [1:0]        idx,
  input  logic [7:0]        data,
  input  logic              do_mask,
  input  logic              do_unmask,
  input  logic              step,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [IOP_W-1:0]  iop_q,
  output logic [7:0]        mode_q,
  output logic              tc_q,
  output logic              active
);
  localparam int AB = ADDR_W / 8;
  localparam int CB = CNT_W / 8;
  localparam int IB = IOP_W / 8;

  logic masked_q;
  assign active = !masked_q && mode_q[MB_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      iop_q    <= '0;
      mode_q   <= '0;
      tc_q     <= 1'b0;
      masked_q <= 1'b1;
    end else begin
      // transfer progress first; bus writes below take precedence
      if (step && active) begin
        addr_q <= addr_q + (mode_q[MB_WIDE] ? ADDR_W'(2) : ADDR_W'(1));
        if (cnt_q == '0) begin
          cnt_q    <= '1;
          tc_q     <= 1'b1;
          masked_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
      for (int b = 0; b < AB; b++)
        if (wr_addr && idx == 2'(b)) addr_q[b*8 +: 8] <= data;
      for (int b = 0; b < CB; b++)
        if (wr_cnt && idx == 2'(b)) cnt_q[b*8 +: 8] <= data;
      for (int b = 0; b < IB; b++)
        if (wr_iop && idx == 2'(b)) iop_q[b*8 +: 8] <= data;
      if (wr_mode) mode_q <= data;
      if (do_mask) masked_q <= 1'b1;
      if (do_unmask) begin
        masked_q <= 1'b0;
        tc_q     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_cmd_front.sv
module dma_cmd_front import dma_fe_pkg::*; #(
  parameter int                NCH      = 8,
  parameter int                ADDR_W   = 24,
  parameter int                CNT_W    = 16,
  parameter int                IOP_W    = 16,
  parameter int                BUS_AW   = 8,
  parameter logic [BUS_AW-1:0] CMD_OFS  = 8'h18,
  parameter logic [BUS_AW-1:0] DATA_OFS = 8'h1A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              xfer_done,
  input  logic [3:0]        xfer_ch,
  input  logic [3:0]        sel_ch,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [IOP_W-1:0]  sel_iop,
  output logic [7:0]        sel_mode,
  output logic [NCH-1:0]    ch_active,
  output logic [NCH-1:0]    tc_flag
);
  localparam int AB = ADDR_W / 8;
  localparam int CB = CNT_W / 8;
  localparam int IB = IOP_W / 8;

  fe_wr_t     wr;
  fe_rd_t     rd;
  logic       mask_cmd, unmask_cmd;
  logic [3:0] cmd_ch;

  logic [ADDR_W-1:0] c_addr [NCH];
  logic [CNT_W-1:0]  c_cnt  [NCH];
  logic [IOP_W-1:0]  c_iop  [NCH];
  logic [7:0]        c_mode [NCH];

  dma_fe_decode #(
    .BUS_AW(BUS_AW), .CMD_OFS(CMD_OFS), .DATA_OFS(DATA_OFS),
    .ADDR_BYTES(AB), .CNT_BYTES(CB), .IOP_BYTES(IB)
  ) u_dec (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wr_o(wr), .rd_o(rd), .mask_o(mask_cmd), .unmask_o(unmask_cmd),
    .cmd_ch_o(cmd_ch)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    logic hit;
    assign hit = (wr.ch == 4'(gi));
    dma_fe_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IOP_W(IOP_W)) u_ch (
      .clk(clk), .rst(rst),
      .wr_iop(wr.iop && hit), .wr_addr(wr.addr && hit),
      .wr_cnt(wr.cnt && hit), .wr_mode(wr.mode && hit),
      .idx(wr.idx), .data(wr.data),
      .do_mask(mask_cmd && cmd_ch == 4'(gi)),
      .do_unmask(unmask_cmd && cmd_ch == 4'(gi)),
      .step(xfer_done && xfer_ch == 4'(gi)),
      .addr_q(c_addr[gi]), .cnt_q(c_cnt[gi]), .iop_q(c_iop[gi]),
      .mode_q(c_mode[gi]), .tc_q(tc_flag[gi]), .active(ch_active[gi])
    );
  end

  logic [7:0] rd_byte;
  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < NCH; i++) begin
      if (rd.ch == 4'(i)) begin
        if (rd.sel_cnt) begin
          for (int b = 0; b < CB; b++)
            if (rd.idx == 2'(b)) rd_byte = c_cnt[i][b*8 +: 8];
        end else begin
          for (int b = 0; b < AB; b++)
            if (rd.idx == 2'(b)) rd_byte = c_addr[i][b*8 +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
      sel_addr  <= '0;
      sel_iop   <= '0;
      sel_mode  <= '0;
    end else begin
      bus_rdata <= rd.go ? rd_byte : 8'h00;
      sel_addr  <= '0;
      sel_iop   <= '0;
      sel_mode  <= '0;
      for (int i = 0; i < NCH; i++) begin
        if (sel_ch == 4'(i)) begin
          sel_addr <= c_addr[i];
          sel_iop  <= c_iop[i];
          sel_mode <= c_mode[i];
        end
      end
    end
  end
endmodule

// File: rtl/dma_cmd_front_chk.sv
module dma_cmd_front_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [7:0]     bus_rdata,
  input logic           xfer_done,
  input logic [NCH-1:0] ch_active,
  input logic [NCH-1:0] tc_flag
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ch_active == '0 && tc_flag == '0 && bus_rdata == 8'h00));

  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == 8'h00));

  for (genvar i = 0; i < NCH; i++) begin : g_p
    // R10
    tc_masks_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(tc_flag[i]) |-> !ch_active[i]);
    // R10
    tc_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(tc_flag[i]) |-> $past(xfer_done));
    // R8
    act_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ch_active[i]) |-> $past(bus_wr));
    // R8
    act_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(ch_active[i]) |-> $past(bus_wr || xfer_done));
  end
endmodule

bind dma_cmd_front dma_cmd_front_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .xfer_done(xfer_done),
  .ch_active(ch_active), .tc_flag(tc_flag)
);

// File: tb/sim_dma_cmd_front.sv
`timescale 1ns/1ps
module sim_dma_cmd_front;
  localparam int NCH = 8;
  localparam logic [7:0] CMD = 8'h18;
  localparam logic [7:0] DAT = 8'h1A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, xfer_done = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic [3:0] xfer_ch = 0, sel_ch = 0;
  logic [7:0] bus_rdata, sel_mode;
  logic [23:0] sel_addr;
  logic [15:0] sel_iop;
  logic [NCH-1:0] ch_active, tc_flag;

  always #2 clk = ~clk;

  dma_cmd_front #(.NCH(NCH)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_done(xfer_done), .xfer_ch(xfer_ch), .sel_ch(sel_ch),
    .sel_addr(sel_addr), .sel_iop(sel_iop), .sel_mode(sel_mode),
    .ch_active(ch_active), .tc_flag(tc_flag)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_addr[16], m_cnt[16], m_iop[16], m_mode[16];
  bit m_mask[16], m_tc[16];
  int m_op, m_ch, m_ptr;
  bit m_vld;
  int e_rdata, e_saddr, e_siop, e_smode;

  function automatic int op_len(int op);
    case (op)
      0: return 2;  2: return 3;  3: return 3;
      4: return 2;  5: return 2;  7: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) begin
        m_addr[i] = 0; m_cnt[i] = 0; m_iop[i] = 0; m_mode[i] = 0;
        m_mask[i] = 1; m_tc[i] = 0;
      end
      m_op = 0; m_ch = 0; m_ptr = 0; m_vld = 0;
      e_rdata = 0; e_saddr = 0; e_siop = 0; e_smode = 0;
    end else begin
      int sc;
      sc = sel_ch;
      if (sc < NCH) begin
        e_saddr = m_addr[sc]; e_siop = m_iop[sc]; e_smode = m_mode[sc];
      end else begin
        e_saddr = 0; e_siop = 0; e_smode = 0;
      end
      e_rdata = 0;
      if (bus_rd && bus_addr == DAT && m_vld && (m_op == 3 || m_op == 5)
          && m_ptr < op_len(m_op)) begin
        if (m_ch < NCH)
          e_rdata = ((m_op == 3 ? m_addr[m_ch] : m_cnt[m_ch]) >> (8*m_ptr)) & 8'hFF;
        m_ptr++;
      end
      if (xfer_done && xfer_ch < NCH && !m_mask[xfer_ch] && m_mode[xfer_ch][2]) begin
        m_addr[xfer_ch] = (m_addr[xfer_ch] + (m_mode[xfer_ch][6] ? 2 : 1)) & 24'hFFFFFF;
        if (m_cnt[xfer_ch] == 0) begin
          m_cnt[xfer_ch] = 16'hFFFF; m_tc[xfer_ch] = 1; m_mask[xfer_ch] = 1;
        end else m_cnt[xfer_ch]--;
      end
      if (bus_wr && bus_addr == CMD) begin
        m_op = bus_wdata[7:4]; m_ch = bus_wdata[3:0]; m_ptr = 0; m_vld = 1;
        if (m_op == 9 && m_ch < NCH) m_mask[m_ch] = 1;
        if (m_op == 10 && m_ch < NCH) begin m_mask[m_ch] = 0; m_tc[m_ch] = 0; end
      end else if (bus_wr && bus_addr == DAT && m_vld && m_ptr < op_len(m_op)) begin
        if (m_ch < NCH) begin
          int sh, v;
          sh = 8*m_ptr; v = bus_wdata;
          case (m_op)
            0: m_iop[m_ch]  = (m_iop[m_ch]  & ~(255 << sh)) | (v << sh);
            2: m_addr[m_ch] = (m_addr[m_ch] & ~(255 << sh)) | (v << sh);
            4: m_cnt[m_ch]  = (m_cnt[m_ch]  & ~(255 << sh)) | (v << sh);
            7: m_mode[m_ch] = v;
            default: ;
          endcase
        end
        if (m_op == 0 || m_op == 2 || m_op == 4 || m_op == 7) m_ptr++;
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NCH-1:0] ea, et;
      for (int i = 0; i < NCH; i++) begin
        ea[i] = !m_mask[i] && m_mode[i][2];
        et[i] = m_tc[i];
      end
      chk("R3 rdata model", bus_rdata, e_rdata);
      chk("R8 ch_active model", ch_active, ea);
      chk("R10 tc_flag model", tc_flag, et);
      chk("R9 sel_addr model", sel_addr, e_saddr);
      chk("R5 sel_iop model", sel_iop, e_siop);
      chk("R6 sel_mode model", sel_mode, e_smode);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_w(logic [7:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_r(output logic [7:0] d);
    bus_rd = 1; bus_addr = DAT;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic strobe(logic [3:0] ch);
    xfer_done = 1; xfer_ch = ch;
    @(negedge clk);
    xfer_done = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      done = 1;
      report();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    chk("R1 ch_active", ch_active, 0);
    chk("R1 tc_flag", tc_flag, 0);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 sel_addr", sel_addr, 0);

    bus_w(DAT, 8'h55); idle(2);
    chk("R7 data before command", sel_iop, 0);

    sel_ch = 1;
    bus_w(CMD, 8'h91); bus_w(CMD, 8'h71); bus_w(DAT, 8'h05); bus_w(DAT, 8'hFF);
    idle(2);
    chk("R6 mode byte", sel_mode, 8'h05);
    chk("R8 masked with enable", ch_active, 0);
    bus_w(CMD, 8'h21); bus_w(DAT, 8'h34); bus_w(DAT, 8'h12); bus_w(DAT, 8'hAB);
    bus_w(DAT, 8'h99); idle(2);
    chk("R3 address load", sel_addr, 24'hAB1234);
    chk("R7 extra byte ignored", sel_addr, 24'hAB1234);
    bus_w(CMD, 8'h41); bus_w(DAT, 8'h02); bus_w(DAT, 8'h00);
    bus_w(CMD, 8'h01); bus_w(DAT, 8'hCD); bus_w(DAT, 8'hAB); idle(2);
    chk("R5 io port", sel_iop, 16'hABCD);
    bus_w(CMD, 8'hA1);
    chk("R8 unmask", ch_active, 8'h02);
    bus_w(8'h19, 8'h91);
    chk("R2 other offset ignored", ch_active, 8'h02);

    bus_w(CMD, 8'h31);
    bus_r(r); chk("R3 get addr b0", r, 8'h34);
    bus_r(r); chk("R3 get addr b1", r, 8'h12);
    bus_r(r); chk("R3 get addr b2", r, 8'hAB);
    bus_r(r); chk("R11 read past end", r, 8'h00);
    bus_w(CMD, 8'h51);
    bus_r(r); chk("R4 get count b0", r, 8'h02);
    bus_r(r); chk("R4 get count b1", r, 8'h00);

    bus_w(CMD, 8'h21); bus_w(DAT, 8'h11);
    bus_w(CMD, 8'h21); bus_w(DAT, 8'h78); bus_w(DAT, 8'h56); bus_w(DAT, 8'h34);
    idle(2);
    chk("R2 pointer restart", sel_addr, 24'h345678);
    bus_r(r); chk("R11 read under set command", r, 8'h00);

    strobe(1); strobe(1);
    chk("R9 no tc yet", tc_flag, 0);
    idle(1);
    chk("R9 addr step 8-bit", sel_addr, 24'h34567A);
    strobe(1);
    chk("R10 tc set", tc_flag, 8'h02);
    chk("R10 self mask", ch_active, 0);
    idle(1);
    chk("R9 addr after last", sel_addr, 24'h34567B);
    bus_w(CMD, 8'h51);
    bus_r(r); chk("R10 count wrap b0", r, 8'hFF);
    bus_r(r); chk("R10 count wrap b1", r, 8'hFF);
    strobe(1); idle(1);
    chk("R8 strobe on masked", sel_addr, 24'h34567B);
    bus_w(CMD, 8'hA1);
    chk("R10 unmask clears tc", tc_flag, 0);

    sel_ch = 2;
    bus_w(CMD, 8'h92); bus_w(CMD, 8'h72); bus_w(DAT, 8'h4C);
    bus_w(CMD, 8'h22); bus_w(DAT, 8'h00); bus_w(DAT, 8'h10); bus_w(DAT, 8'h00);
    bus_w(CMD, 8'h42); bus_w(DAT, 8'h00); bus_w(DAT, 8'h00);
    bus_w(CMD, 8'hA2);
    chk("R8 two active", ch_active, 8'h06);
    strobe(2);
    chk("R10 tc at zero count", tc_flag, 8'h04);
    idle(1);
    chk("R9 addr step 16-bit", sel_addr, 24'h001002);
    chk("R6 wide mode kept", sel_mode, 8'h4C);

    bus_w(CMD, 8'h62); bus_w(DAT, 8'h77);
    bus_w(CMD, 8'hB2); bus_w(DAT, 8'h77);
    bus_w(CMD, 8'hE2); bus_w(DAT, 8'h01); idle(2);
    chk("R7 unassigned opcodes mode", sel_mode, 8'h4C);
    chk("R7 unassigned opcodes addr", sel_addr, 24'h001002);
    bus_w(CMD, 8'h2A); bus_w(DAT, 8'h01); bus_w(DAT, 8'h02); bus_w(DAT, 8'h03);
    bus_w(CMD, 8'h9F);
    chk("R7 out-of-range channel", ch_active, 8'h02);
    bus_w(CMD, 8'h3A);
    bus_r(r); chk("R7 get on missing channel", r, 8'h00);

    sel_ch = 3;
    bus_w(CMD, 8'hA3);
    chk("R8 unmasked without enable", ch_active, 8'h02);
    strobe(3); idle(1);
    chk("R9 inactive strobe", sel_addr, 0);

    // mixed traffic, checked cycle by cycle against the model
    for (int k = 0; k < 600; k++) begin
      int sel;
      logic [3:0] ops [8] = '{4'h0, 4'h2, 4'h3, 4'h4, 4'h5, 4'h7, 4'h9, 4'hA};
      sel = $urandom_range(0, 9);
      sel_ch = 4'($urandom_range(0, NCH - 1));
      xfer_done = ($urandom_range(0, 2) == 0);
      xfer_ch = 4'($urandom_range(0, NCH));
      bus_wr = 0; bus_rd = 0;
      if (sel < 3) begin
        bus_wr = 1; bus_addr = CMD;
        bus_wdata = {ops[$urandom_range(0, 7)], 4'($urandom_range(0, NCH))};
      end else if (sel < 7) begin
        bus_wr = 1; bus_addr = DAT; bus_wdata = 8'($urandom_range(0, 255));
      end else if (sel < 9) begin
        bus_rd = 1; bus_addr = DAT;
      end
      @(negedge clk);
    end
    bus_wr = 0; bus_rd = 0; xfer_done = 0;
    idle(2);
    done = 1;
    report();
  end
endmodule